// File: doc/BRIEF.md
# Base-Index-Displacement Effective Address Unit

This block forms operand addresses for a decoded instruction. It adds the contents of a base register, the contents of an optional index register and an unsigned 12-bit displacement, and returns the low 24 bits of that sum. The inputs are register numbers and a displacement. A register number of zero in either the base or the index field means "no register". It does not select register 0.

The block holds a 16-entry, 32-bit general register file. The file has one write port for loading values and two read ports, one for the base and one for the index. A request is presented for one cycle and its result appears, registered, on the following cycle with a valid flag.

A second request kind serves shift-type instructions. It adds base and displacement and ignores the index completely. It returns that raw sum together with its low 6 bits as a shift count.

Top module: `eag_top`

## Requirements
- R1: While reset is asserted and after its release, before any request, `out_valid`, `out_addr` and `out_shift` are all zero.
- R2: For an address request (`req_kind` = 0) with `req_use_index` = 1, `out_addr` one cycle later equals base register + index register + displacement, taken over the low 24 bits.
- R3: A base field of 0 contributes zero to the sum, whatever value register 0 holds.
- R4: An index field of 0 contributes zero to the sum, whatever value register 0 holds.
- R5: For an address request with `req_use_index` = 0, the index field has no effect on `out_addr`.
- R6: A shift request (`req_kind` = 1) ignores the index field and `req_use_index`. `out_addr` is base + displacement (low 24 bits) and `out_shift` is bits [5:0] of that value. With base 0 and displacement 0x00C, the count is 12.
- R7: For an address request, `out_shift` is zero.
- R8: If a register is written in the same cycle that a request reads it as base or as index, the request uses the newly written value.
- R9: `out_valid` is high in exactly the cycle after each request cycle. In a cycle with no request, `out_valid` is low and `out_addr`/`out_shift` keep their previous values.
- R10: The sum wraps modulo 2^24. Register bits above bit 23 never affect `out_addr`.
- R11: The displacement is zero-extended, so 0xFFF adds 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Value to write |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 = address request, 1 = shift-count request |
| req_base | input | 4 | Base register number, 0 = none |
| req_index | input | 4 | Index register number, 0 = none |
| req_disp | input | 12 | Unsigned displacement |
| req_use_index | input | 1 | Address request includes the index term |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_addr | output | 24 | Effective address or base+displacement |
| out_shift | output | 6 | Shift count for shift requests, zero otherwise |

## Verification
The bench writes a non-zero value into register 0 and then uses zero base and index fields. A design that read register 0 in these cases would offset every such address by that value. It pairs an indexed request with the same request with an index of 0 and expects a difference of exactly 4. It also sends shift requests that carry a live index field, which catches a design that added the index anyway. Writes in the same cycle as a request catch a register file that returns stale data. Carry-out and all-ones displacement cases catch sign extension of the displacement and a sum wider than 24 bits. Idle cycles check that the valid flag drops and that the result is held.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic {
    REQ_ADDR  = 1'b0,
    REQ_SHIFT = 1'b1
  } req_kind_e;
endpackage

// File: rtl/eag_regfile.sv
module eag_regfile #(
  parameter int REG_COUNT = 16,
  parameter int DATA_W    = 32,
  parameter int PORTS     = 2,
  localparam int SEL_W    = $clog2(REG_COUNT)
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [PORTS-1:0][SEL_W-1:0]  rd_sel,
  output logic [PORTS-1:0][DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [REG_COUNT];

  // storage array: no reset, loaded through the write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_sel] <= wr_data;
    end
  end

  // read ports with same-cycle write forwarding
  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_comb begin
      if (wr_en && (wr_sel == rd_sel[p])) begin
        rd_data[p] = wr_data;
      end else begin
        rd_data[p] = mem_q[rd_sel[p]];
      end
    end
  end
endmodule

// File: rtl/eag_term_gate.sv
module eag_term_gate #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              use_term,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] term
);
  // field value zero selects no register at all
  always_comb begin
    if (use_term && (sel != '0)) begin
      term = data;
    end else begin
      term = '0;
    end
  end
endmodule

// File: rtl/eag_sum_stage.sv
module eag_sum_stage
  import eag_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DISP_W  = 12,
  parameter int ADDR_W  = 24,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  req_kind_e          req_kind,
  input  logic [DATA_W-1:0]  base_term,
  input  logic [DATA_W-1:0]  index_term,
  input  logic [DISP_W-1:0]  disp,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [SHIFT_W-1:0] out_shift
);
  logic [DATA_W-1:0]  sum_full;
  logic [ADDR_W-1:0]  addr_d;
  logic [SHIFT_W-1:0] shift_d;
  logic               unused_hi;

  always_comb begin
    sum_full = base_term + index_term + DATA_W'(disp);
    addr_d   = sum_full[ADDR_W-1:0];
    if (req_kind == REQ_SHIFT) begin
      shift_d = addr_d[SHIFT_W-1:0];
    end else begin
      shift_d = '0;
    end
  end

  assign unused_hi = ^sum_full[DATA_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_shift <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr  <= addr_d;
        out_shift <= shift_d;
      end
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int DATA_W    = 32,
  parameter int DISP_W    = 12,
  parameter int ADDR_W    = 24,
  parameter int SHIFT_W   = 6,
  localparam int SEL_W    = $clog2(REG_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               req_valid,
  input  logic               req_kind,
  input  logic [SEL_W-1:0]   req_base,
  input  logic [SEL_W-1:0]   req_index,
  input  logic [DISP_W-1:0]  req_disp,
  input  logic               req_use_index,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [SHIFT_W-1:0] out_shift
);
  localparam int PORT_BASE  = 0;
  localparam int PORT_INDEX = 1;

  logic [1:0]              rst_pipe;
  logic                    rst_q;
  req_kind_e               kind;
  logic                    index_on;
  logic [1:0][SEL_W-1:0]   rd_sel;
  logic [1:0][DATA_W-1:0]  rd_data;
  logic [DATA_W-1:0]       base_term;
  logic [DATA_W-1:0]       index_term;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  assign kind     = req_kind_e'(req_kind);
  assign index_on = (kind == REQ_ADDR) && req_use_index;
  assign rd_sel[PORT_BASE]  = req_base;
  assign rd_sel[PORT_INDEX] = req_index;

  eag_regfile #(
    .REG_COUNT(REG_COUNT), .DATA_W(DATA_W), .PORTS(2)
  ) rf_i (
    .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  eag_term_gate #(.DATA_W(DATA_W), .SEL_W(SEL_W)) base_gate_i (
    .use_term(1'b1), .sel(req_base), .data(rd_data[PORT_BASE]),
    .term(base_term)
  );

  eag_term_gate #(.DATA_W(DATA_W), .SEL_W(SEL_W)) index_gate_i (
    .use_term(index_on), .sel(req_index), .data(rd_data[PORT_INDEX]),
    .term(index_term)
  );

  eag_sum_stage #(
    .DATA_W(DATA_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)
  ) sum_i (
    .clk(clk), .rst_n(rst_q), .req_valid(req_valid), .req_kind(kind),
    .base_term(base_term), .index_term(index_term), .disp(req_disp),
    .out_valid(out_valid), .out_addr(out_addr), .out_shift(out_shift)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int SEL_W   = 4,
  parameter int DISP_W  = 12,
  parameter int ADDR_W  = 24,
  parameter int SHIFT_W = 6
) (
  input logic               clk,
  input logic               rst_q,
  input logic               req_valid,
  input logic               req_kind,
  input logic [SEL_W-1:0]   req_base,
  input logic [SEL_W-1:0]   req_index,
  input logic [DISP_W-1:0]  req_disp,
  input logic               req_use_index,
  input logic               out_valid,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [SHIFT_W-1:0] out_shift
);
  // R9
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> out_valid);

  // R9
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_shift)));

  // R3
  disp_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && (req_base == '0) &&
     (req_kind || !req_use_index || (req_index == '0)))
    |=> (out_addr == {{(ADDR_W-DISP_W){1'b0}}, $past(req_disp)}));

  // R6
  shift_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_kind) |=> (out_shift == out_addr[SHIFT_W-1:0]));

  // R7
  addr_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && !req_kind) |=> (out_shift == '0));
endmodule

bind eag_top eag_checker #(
  .SEL_W(SEL_W), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)
) chk_i (
  .clk(clk), .rst_q(rst_q), .req_valid(req_valid), .req_kind(req_kind),
  .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
  .req_use_index(req_use_index), .out_valid(out_valid),
  .out_addr(out_addr), .out_shift(out_shift)
);

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_kind = 1'b0;
  logic [3:0]  req_base = '0;
  logic [3:0]  req_index = '0;
  logic [11:0] req_disp = '0;
  logic        req_use_index = 1'b0;
  logic        out_valid;
  logic [23:0] out_addr;
  logic [5:0]  out_shift;

  logic [31:0] model [16];
  int checks = 0;
  int fails  = 0;
  logic [23:0] ref_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  eag_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
    .req_use_index(req_use_index), .out_valid(out_valid),
    .out_addr(out_addr), .out_shift(out_shift)
  );

  function automatic logic [23:0] exp_addr(logic k, logic [3:0] b,
      logic [3:0] x, logic [11:0] d, logic ui);
    logic [31:0] s;
    s = {20'd0, d};
    if (b != 0) s = s + model[b];
    if (!k && ui && x != 0) s = s + model[x];
    return s[23:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(logic [3:0] s, logic [31:0] v);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model[s] = v;
  endtask

  // issue one request at a negedge, check the result one negedge later
  task automatic issue(logic k, logic [3:0] b, logic [3:0] x,
      logic [11:0] d, logic ui, string tag);
    logic [23:0] ea;
    ea = exp_addr(k, b, x, d, ui);
    req_valid = 1'b1; req_kind = k; req_base = b; req_index = x;
    req_disp = d; req_use_index = ui;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " addr"}, {8'd0, out_addr}, {8'd0, ea});
    chk({tag, " shift"}, {26'd0, out_shift}, k ? {26'd0, ea[5:0]} : 32'd0);
    ref_a = ea;
  endtask

  // request with a write to the same register in the same cycle
  task automatic issue_bypass(logic [3:0] s, logic [31:0] v, logic use_as_base);
    logic [23:0] ea;
    model[s] = v;
    if (use_as_base) ea = exp_addr(1'b0, s, 4'd0, 12'h010, 1'b1);
    else             ea = exp_addr(1'b0, 4'd0, s, 12'h010, 1'b1);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    req_valid = 1'b1; req_kind = 1'b0; req_disp = 12'h010; req_use_index = 1'b1;
    req_base = use_as_base ? s : 4'd0;
    req_index = use_as_base ? 4'd0 : s;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8 bypass addr", {8'd0, out_addr}, {8'd0, ea});
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] a0;
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset addr", {8'd0, out_addr}, 32'd0);
    chk("R1 reset shift", {26'd0, out_shift}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post-release valid", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 16; i++) write_reg(4'(i), $urandom());
    write_reg(4'd0, 32'hDEAD_BEEF);
    chk("R1 no valid without request", {31'd0, out_valid}, 32'd0);

    // R3 / R4 / R6: register 0 never used, shift count from displacement
    issue(1'b1, 4'd0, 4'd0, 12'h00C, 1'b0, "R6 shift disp 12");
    chk("R6 count is 12", {26'd0, out_shift}, 32'd12);
    issue(1'b0, 4'd0, 4'd0, 12'h345, 1'b1, "R3 R4 zero fields");

    // R2 / R4: index 7 = 4 adds exactly 4
    write_reg(4'd12, 32'h0004_0000);
    write_reg(4'd7, 32'd4);
    issue(1'b0, 4'd12, 4'd0, 12'h123, 1'b1, "R4 no index");
    a0 = out_addr;
    issue(1'b0, 4'd12, 4'd7, 12'h123, 1'b1, "R2 indexed");
    chk("R2 index adds 4", {8'd0, out_addr}, {8'd0, a0 + 24'd4});

    // R5: index disabled
    issue(1'b0, 4'd12, 4'd7, 12'h123, 1'b0, "R5 index off");
    chk("R5 same as no index", {8'd0, out_addr}, {8'd0, a0});

    // R6: shift request ignores index
    issue(1'b1, 4'd12, 4'd7, 12'h0FF, 1'b1, "R6 shift ignores index");

    // R10 wrap and high bits, R11 zero extension
    write_reg(4'd1, 32'hAB_FFFFFF);
    write_reg(4'd2, 32'h77_000001);
    issue(1'b0, 4'd1, 4'd2, 12'h000, 1'b1, "R10 wrap");
    chk("R10 wraps to zero", {8'd0, out_addr}, 32'd0);
    issue(1'b0, 4'd0, 4'd0, 12'hFFF, 1'b0, "R11 disp FFF");
    chk("R11 is 4095", {8'd0, out_addr}, 32'd4095);

    // R9 idle hold
    @(negedge clk);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 idle hold", {8'd0, out_addr}, {8'd0, ref_a});

    // R8 write-first on base and index ports
    issue_bypass(4'd9, 32'h0012_3400, 1'b1);
    issue_bypass(4'd10, 32'h0000_0ABC, 1'b0);

    // R2 random mix with occasional writes and idle gaps
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) write_reg(4'($urandom()), $urandom());
      issue(1'($urandom()), 4'($urandom()), 4'($urandom()),
            12'($urandom()), 1'($urandom()), "R2 random");
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        chk("R9 random idle", {31'd0, out_valid}, 32'd0);
        chk("R9 random hold", {8'd0, out_addr}, {8'd0, ref_a});
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule